// File: doc/BRIEF.md
# Byte-wide Memory Chip-Enable Decoder

This block sits between a processor core and a non-multiplexed byte-wide SRAM bus. Each cycle it takes one 16-bit access (an instruction fetch or a data read or write) and the current memory configuration. One clock later it drives the registered bus controls: four active-low chip enables, a non-backed copy of the first chip enable, four active-low peripheral enables, an active-low write strobe, the low address lines, and a flag. The flag tells the core to run the access on its external expanded bus instead.

Two sizing schemes are supported. With `size_multi` high, the 128K byte-wide space is built from 32K RAMs, one per chip enable. With `size_multi` low, a single 128K RAM is used: the second and third chip enables become address bits 16 and 15, and the fourth stays idle. The configuration also chooses between two maps. In the fixed-range map, program and data each get 32K or 64K. In the split map, one 64K region is divided at a loadable boundary, with program below the boundary and data above it. A peripheral-select bit sends every data access to one of four 16K peripheral enables. A hold input, driven by reset or power-fail logic, forces every strobe inactive.

Top module: `bwbus_decode`

## Requirements
- R1: While `rst` or `hold` is high at a clock edge, the outputs after that edge are: all `ce_n` bits 1, `ce1_unbacked_n` 1, all `pe_n` bits 1, `rw_n` 1 and `ext_bus` 0.
- R2: In multi-RAM mode (`size_multi`=1), a byte-wide access goes to physical address `phys`. Only `ce_n[phys[16:15]]` is driven low. In the fixed-range map, a program fetch uses `phys` = {0, addr} and a data access uses `phys` = {1, addr}.
- R3: In single-RAM mode (`size_multi`=0), a byte-wide access drives `ce_n[0]` low, `ce_n[1]` to `phys[16]`, `ce_n[2]` to `phys[15]`, and `ce_n[3]` high. With no byte-wide access, all four are high.
- R4: When `periph_sel`=1, every data access drives only `pe_n[addr[15:14]]` low and no chip enable. This holds regardless of range, map or size.
- R5: In the fixed-range map, a program fetch is byte-wide when `prog_full`=1 or addr < 8000h. A data access is byte-wide when `data_full`=1 or addr < 8000h. Any other access sets `ext_bus` to 1 and leaves every enable and `rw_n` high.
- R6: The split map applies only when `split_mode`=1 and `size_multi`=1; in single-RAM mode it is forced off. In the split map, both kinds of access use `phys` = {0, addr}. A fetch is byte-wide when addr[15:12] < boundary. A data access is byte-wide when addr[15:12] >= boundary. Otherwise `ext_bus` is 1.
- R7: The boundary register resets to 8. It takes `bound_in` only on a clock edge where `bound_load`=1, and an access in the following cycle uses the new value. At all other times it holds its value.
- R8: `rw_n` goes low only for a data write that reaches a byte-wide or peripheral enable. A program fetch never drives `rw_n` low, even with `acc_write`=1.
- R9: `ce1_unbacked_n` always equals `ce_n[0]`.
- R10: At most one of the decoded enables (all `ce_n` bits in multi-RAM mode, `ce_n[0]` and `ce_n[3]` in single-RAM mode, and all `pe_n` bits) is low at a time. A program fetch never drives a `pe_n` bit low.
- R11: Outputs are registered with one cycle of latency. A cycle with `acc_valid`=0 leaves all enables and `rw_n` high and `ext_bus` 0.
- R12: `bw_addr` carries addr[14:0] of the access presented one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Reset/power-fail hold; forces all strobes inactive |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_fetch | input | 1 | 1 = program fetch, 0 = data access |
| acc_write | input | 1 | Write intent |
| acc_addr | input | 16 | Access address |
| size_multi | input | 1 | 1 = four 32K RAMs, 0 = one 128K RAM |
| split_mode | input | 1 | 1 = split map with loadable boundary |
| prog_full | input | 1 | Fixed map: program range 64K (1) or 32K (0) |
| data_full | input | 1 | Fixed map: data range 64K (1) or 32K (0) |
| periph_sel | input | 1 | Send data accesses to the peripheral enables |
| bound_load | input | 1 | Load strobe for the boundary register |
| bound_in | input | 4 | New boundary, in 4K steps |
| ce_n | output | 4 | Chip enables (bits 1 and 2 are address bits 16 and 15 in single-RAM mode) |
| ce1_unbacked_n | output | 1 | Non-backed copy of ce_n[0] |
| pe_n | output | 4 | Peripheral enables, one per 16K of data space |
| rw_n | output | 1 | Active-low write strobe |
| ext_bus | output | 1 | Access must go to the external expanded bus |
| bw_addr | output | 15 | Byte-wide address lines |

## Verification
The bench sweeps 64 addresses spread over the whole 64K space. Each address is tried as a fetch, a data read, a data write, and a fetch with write intent. This is repeated for every combination of size mode, map, both range widths and peripheral select. The address sweep separates the 16K peripheral slices, the 32K chip-enable blocks and the range cut-offs. The four access kinds separate the program and data physical halves, and they show write protection. Walking the boundary over all sixteen values, in split and forced-off settings, exposes off-by-one errors at the boundary. Idle cycles, hold cycles and loads of the boundary that are not strobed confirm that nothing leaks through.

// File: rtl/bwbus_pkg.sv
package bwbus_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_EXT  = 2'd1,
    TGT_MEM  = 2'd2,
    TGT_PERI = 2'd3
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic wr;
  } route_t;

endpackage

// File: rtl/bwbus_bound_reg.sv
module bwbus_bound_reg #(
  parameter int PART_W     = 4,
  parameter int PART_RESET = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [PART_W-1:0] value_i,
  output logic [PART_W-1:0] bound_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bound_o <= PART_W'(PART_RESET);
    end else if (load_i) begin
      bound_o <= value_i;
    end
  end

endmodule

// File: rtl/bwbus_region_map.sv
module bwbus_region_map
  import bwbus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BLOCK_W = 15,
  parameter int PART_W  = 4
) (
  input  logic                      valid_i,
  input  logic                      fetch_i,
  input  logic                      write_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      size_multi_i,
  input  logic                      split_mode_i,
  input  logic                      prog_full_i,
  input  logic                      data_full_i,
  input  logic                      periph_sel_i,
  input  logic [PART_W-1:0]         bound_i,
  output route_t                    route_o,
  output logic [ADDR_W-BLOCK_W:0]   blk_o
);

  localparam int BLK_W = ADDR_W + 1 - BLOCK_W;

  logic              split_on;
  logic [PART_W-1:0] upper;
  logic              high_half;
  logic              mapped;

  assign split_on  = split_mode_i & size_multi_i;
  assign upper     = addr_i[ADDR_W-1 -: PART_W];
  assign high_half = addr_i[ADDR_W-1];

  always_comb begin
    route_o = '{tgt: TGT_NONE, wr: 1'b0};
    blk_o   = '0;
    mapped  = 1'b0;
    if (valid_i) begin
      if (fetch_i) begin
        mapped      = split_on ? (upper < bound_i) : (prog_full_i | ~high_half);
        route_o.tgt = mapped ? TGT_MEM : TGT_EXT;
        blk_o       = {1'b0, addr_i[ADDR_W-1 -: BLK_W-1]};
      end else if (periph_sel_i) begin
        route_o.tgt = TGT_PERI;
      end else begin
        mapped      = split_on ? (upper >= bound_i) : (data_full_i | ~high_half);
        route_o.tgt = mapped ? TGT_MEM : TGT_EXT;
        blk_o       = {~split_on, addr_i[ADDR_W-1 -: BLK_W-1]};
      end
      route_o.wr = write_i & ~fetch_i &
                   ((route_o.tgt == TGT_MEM) | (route_o.tgt == TGT_PERI));
    end
  end

endmodule

// File: rtl/bwbus_enable_drive.sv
module bwbus_enable_drive
  import bwbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int BLOCK_W  = 15,
  parameter int CE_COUNT = 4,
  parameter int PE_COUNT = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        hold,
  input  logic                        size_multi_i,
  input  route_t                      route_i,
  input  logic [ADDR_W-BLOCK_W:0]     blk_i,
  input  logic [$clog2(PE_COUNT)-1:0] pe_sel_i,
  input  logic [ADDR_W-2:0]           addr_lo_i,
  output logic [CE_COUNT-1:0]         ce_n,
  output logic                        ce1_unbacked_n,
  output logic [PE_COUNT-1:0]         pe_n,
  output logic                        rw_n,
  output logic                        ext_bus,
  output logic [ADDR_W-2:0]           bw_addr
);

  localparam int BLK_W    = ADDR_W + 1 - BLOCK_W;
  localparam int PE_SEL_W = $clog2(PE_COUNT);

  logic                is_mem;
  logic                is_peri;
  logic [CE_COUNT-1:0] ce_nx;
  logic [PE_COUNT-1:0] pe_nx;

  assign is_mem  = (route_i.tgt == TGT_MEM);
  assign is_peri = (route_i.tgt == TGT_PERI);

  for (genvar g = 0; g < CE_COUNT; g++) begin : g_ce
    if (g == 0) begin : g_first
      assign ce_nx[g] = size_multi_i ? ~(is_mem && blk_i == BLK_W'(g)) : ~is_mem;
    end else if (g == 1) begin : g_hi_bit
      assign ce_nx[g] = size_multi_i ? ~(is_mem && blk_i == BLK_W'(g))
                                     : (is_mem ? blk_i[BLK_W-1] : 1'b1);
    end else if (g == 2) begin : g_lo_bit
      assign ce_nx[g] = size_multi_i ? ~(is_mem && blk_i == BLK_W'(g))
                                     : (is_mem ? blk_i[BLK_W-2] : 1'b1);
    end else begin : g_rest
      assign ce_nx[g] = size_multi_i ? ~(is_mem && blk_i == BLK_W'(g)) : 1'b1;
    end
  end

  for (genvar g = 0; g < PE_COUNT; g++) begin : g_pe
    assign pe_nx[g] = ~(is_peri && pe_sel_i == PE_SEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      ce_n           <= '1;
      ce1_unbacked_n <= 1'b1;
      pe_n           <= '1;
      rw_n           <= 1'b1;
      ext_bus        <= 1'b0;
    end else begin
      ce_n           <= ce_nx;
      ce1_unbacked_n <= ce_nx[0];
      pe_n           <= pe_nx;
      rw_n           <= ~route_i.wr;
      ext_bus        <= (route_i.tgt == TGT_EXT);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bw_addr <= '0;
    end else begin
      bw_addr <= addr_lo_i;
    end
  end

endmodule

// File: rtl/bwbus_decode.sv
module bwbus_decode
  import bwbus_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int BLOCK_W    = 15,
  parameter int CE_COUNT   = 1 << (ADDR_W + 1 - BLOCK_W),
  parameter int PE_COUNT   = 4,
  parameter int PART_W     = 4,
  parameter int PART_RESET = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold,
  input  logic                acc_valid,
  input  logic                acc_fetch,
  input  logic                acc_write,
  input  logic [ADDR_W-1:0]   acc_addr,
  input  logic                size_multi,
  input  logic                split_mode,
  input  logic                prog_full,
  input  logic                data_full,
  input  logic                periph_sel,
  input  logic                bound_load,
  input  logic [PART_W-1:0]   bound_in,
  output logic [CE_COUNT-1:0] ce_n,
  output logic                ce1_unbacked_n,
  output logic [PE_COUNT-1:0] pe_n,
  output logic                rw_n,
  output logic                ext_bus,
  output logic [ADDR_W-2:0]   bw_addr
);

  localparam int BLK_W    = ADDR_W + 1 - BLOCK_W;
  localparam int PE_SEL_W = $clog2(PE_COUNT);

  logic [PART_W-1:0] part_q;
  route_t            route;
  logic [BLK_W-1:0]  blk;

  bwbus_bound_reg #(
    .PART_W    (PART_W),
    .PART_RESET(PART_RESET)
  ) u_bound (
    .clk    (clk),
    .rst    (rst),
    .load_i (bound_load),
    .value_i(bound_in),
    .bound_o(part_q)
  );

  bwbus_region_map #(
    .ADDR_W (ADDR_W),
    .BLOCK_W(BLOCK_W),
    .PART_W (PART_W)
  ) u_map (
    .valid_i     (acc_valid),
    .fetch_i     (acc_fetch),
    .write_i     (acc_write),
    .addr_i      (acc_addr),
    .size_multi_i(size_multi),
    .split_mode_i(split_mode),
    .prog_full_i (prog_full),
    .data_full_i (data_full),
    .periph_sel_i(periph_sel),
    .bound_i     (part_q),
    .route_o     (route),
    .blk_o       (blk)
  );

  bwbus_enable_drive #(
    .ADDR_W  (ADDR_W),
    .BLOCK_W (BLOCK_W),
    .CE_COUNT(CE_COUNT),
    .PE_COUNT(PE_COUNT)
  ) u_drive (
    .clk           (clk),
    .rst           (rst),
    .hold          (hold),
    .size_multi_i  (size_multi),
    .route_i       (route),
    .blk_i         (blk),
    .pe_sel_i      (acc_addr[ADDR_W-1 -: PE_SEL_W]),
    .addr_lo_i     (acc_addr[ADDR_W-2:0]),
    .ce_n          (ce_n),
    .ce1_unbacked_n(ce1_unbacked_n),
    .pe_n          (pe_n),
    .rw_n          (rw_n),
    .ext_bus       (ext_bus),
    .bw_addr       (bw_addr)
  );

endmodule

// File: rtl/bwbus_decode_chk.sv
module bwbus_decode_chk #(
  parameter int CE_COUNT = 4,
  parameter int PE_COUNT = 4,
  parameter int PART_W   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                hold,
  input logic                acc_valid,
  input logic                acc_fetch,
  input logic                size_multi,
  input logic                bound_load,
  input logic [PART_W-1:0]   part_q,
  input logic [CE_COUNT-1:0] ce_n,
  input logic                ce1_unbacked_n,
  input logic [PE_COUNT-1:0] pe_n,
  input logic                rw_n,
  input logic                ext_bus
);

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold |=> (&ce_n && &pe_n && rw_n && ce1_unbacked_n && !ext_bus)); // R1

  AST_SINGLE_CE4_IDLE: assert property (@(posedge clk) disable iff (rst)
    !size_multi |=> ce_n[CE_COUNT-1] && ($countones({~ce_n[0], ~pe_n}) <= 1)); // R3

  AST_EXT_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    ext_bus |-> (ce_n[0] && &pe_n && rw_n)); // R5

  AST_BOUND_KEEP: assert property (@(posedge clk) disable iff (rst)
    !bound_load |=> $stable(part_q)); // R7

  AST_FETCH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_fetch) |=> rw_n); // R8

  AST_CE1_COPY: assert property (@(posedge clk) disable iff (rst)
    ce1_unbacked_n == ce_n[0]); // R9

  AST_MULTI_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
    size_multi |=> ($countones({~ce_n, ~pe_n}) <= 1)); // R10

  AST_FETCH_NO_PERI: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_fetch) |=> &pe_n); // R10

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> (ce_n[0] && &pe_n && rw_n && !ext_bus)); // R11

endmodule

bind bwbus_decode bwbus_decode_chk #(
  .CE_COUNT(CE_COUNT),
  .PE_COUNT(PE_COUNT),
  .PART_W  (PART_W)
) u_chk (.*);

// File: tb/bwbus_decode_bench.sv
`timescale 1ns/1ps
module bwbus_decode_bench;

  logic        clk = 1'b0;
  logic        rst, hold, acc_valid, acc_fetch, acc_write;
  logic [15:0] acc_addr;
  logic        size_multi, split_mode, prog_full, data_full, periph_sel;
  logic        bound_load;
  logic [3:0]  bound_in;
  logic [3:0]  ce_n;
  logic        ce1_unbacked_n;
  logic [3:0]  pe_n;
  logic        rw_n, ext_bus;
  logic [14:0] bw_addr;

  int n_checks = 0;
  int n_fail   = 0;
  int bound_m  = 8;
  bit finished = 0;

  always #2 clk = ~clk;

  bwbus_decode u_bwbus_decode (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: addr=%h actual=%h expected=%h", tag, acc_addr, act, exp);
    end
  endtask

  // expected {ce_n, ce1_unbacked_n, pe_n, rw_n, ext_bus}
  function automatic logic [10:0] model(bit v, bit f, bit w, int a);
    logic [3:0] ce = 4'hF;
    logic [3:0] pe = 4'hF;
    bit rwn = 1, ext = 0, mapped;
    int phys;
    bit split_on = split_mode && size_multi;
    if (hold || !v) return {4'hF, 1'b1, 4'hF, 1'b1, 1'b0};
    if (!f && periph_sel) begin
      pe  = ~(4'b1 << (a / 16384));
      rwn = !w;
    end else begin
      if (f) begin
        mapped = split_on ? ((a / 4096) < bound_m) : (prog_full || a < 32768);
        phys = a;
      end else begin
        mapped = split_on ? ((a / 4096) >= bound_m) : (data_full || a < 32768);
        phys = split_on ? a : 65536 + a;
      end
      if (!mapped) ext = 1;
      else begin
        if (size_multi) ce = ~(4'b1 << (phys / 32768));
        else ce = {1'b1, 1'((phys / 32768) % 2), 1'((phys / 65536) % 2), 1'b0};
        rwn = !(w && !f);
      end
    end
    return {ce, ce[0], pe, rwn, ext};
  endfunction

  function automatic string tag_of(bit f, bit w);
    if (!f && periph_sel) return "R4";
    if (split_mode && size_multi) return "R6";
    if (w) return "R8";
    if (!size_multi) return "R3";
    if (!prog_full || !data_full) return "R5";
    return "R2";
  endfunction

  task automatic access(bit v, bit f, bit w, int a, string tag);
    logic [10:0] e;
    acc_valid = v; acc_fetch = f; acc_write = w; acc_addr = 16'(a);
    e = model(v, f, w, a);
    @(posedge clk);
    @(negedge clk);
    chk(tag, {5'd0, ce_n, ce1_unbacked_n, pe_n, rw_n, ext_bus}, {5'd0, e});
    chk("R9", {15'd0, ce1_unbacked_n}, {15'd0, ce_n[0]});
    if (size_multi)
      chk("R10", 16'($countones({~ce_n, ~pe_n}) <= 1), 16'd1);
    if (v && !hold) chk("R12", {1'b0, bw_addr}, {1'b0, 15'(a)});
  endtask

  task automatic load_bound(int b, bit strobe);
    bound_in = 4'(b); bound_load = strobe; acc_valid = 0;
    @(posedge clk);
    @(negedge clk);
    bound_load = 0;
    if (strobe) bound_m = b;
  endtask

  initial begin
    rst = 1; hold = 0; acc_valid = 0; acc_fetch = 0; acc_write = 0; acc_addr = '0;
    size_multi = 1; split_mode = 0; prog_full = 0; data_full = 0; periph_sel = 0;
    bound_load = 0; bound_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", {5'd0, ce_n, ce1_unbacked_n, pe_n, rw_n, ext_bus}, {5'd0, 11'b1111_1_1111_1_0});
    rst = 0;
    // R7: reset value 8 -> fetch at 7000h mapped, 8000h external
    split_mode = 1;
    access(1, 1, 0, 16'h7000, "R7");
    access(1, 1, 0, 16'h8000, "R7");
    // R11: idle cycle
    access(0, 0, 1, 16'h1234, "R11");
    // sweep all configurations
    for (int ps = 0; ps < 2; ps++)
      for (int sz = 0; sz < 2; sz++)
        for (int pm = 0; pm < 2; pm++)
          for (int pf = 0; pf < 2; pf++)
            for (int df = 0; df < 2; df++) begin
              periph_sel = 1'(ps); size_multi = 1'(sz); split_mode = 1'(pm);
              prog_full = 1'(pf); data_full = 1'(df);
              if (pm == 1) load_bound(5 + ps + sz, 1);
              for (int k = 0; k < 4; k++)
                for (int i = 0; i < 64; i++) begin
                  int a = i * 1024 + ((i * 37) % 1024);
                  bit f = (k == 0) || (k == 3);
                  bit w = (k == 2) || (k == 3);
                  access(1, f, w, a, tag_of(f, w));
                end
            end
    // R6: walk the boundary over all values, at and around each edge
    periph_sel = 0; size_multi = 1; split_mode = 1;
    for (int b = 0; b < 16; b++) begin
      load_bound(b, 1);
      access(1, 1, 0, (b * 4096) % 65536, "R6");
      access(1, 0, 1, (b * 4096) % 65536, "R6");
      access(1, 1, 0, (b * 4096 + 65535) % 65536, "R6");
      access(1, 0, 0, (b * 4096 + 65535) % 65536, "R6");
    end
    // R6: split forced off in single-RAM mode
    size_multi = 0; prog_full = 0; data_full = 0;
    access(1, 0, 0, 16'h0100, "R6");
    access(1, 1, 0, 16'h9000, "R6");
    // R7: value without strobe is ignored
    size_multi = 1;
    load_bound(4, 1);
    load_bound(12, 0);
    access(1, 1, 0, 16'h4000, "R7");
    access(1, 0, 0, 16'h4000, "R7");
    access(1, 1, 0, 16'h3FFF, "R7");
    // R1: hold during accesses
    hold = 1;
    access(1, 0, 1, 16'h0010, "R1");
    periph_sel = 1;
    access(1, 0, 1, 16'hC010, "R1");
    hold = 0;
    access(1, 0, 1, 16'hC010, "R4");
    access(0, 1, 0, 16'h0000, "R11");
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule